// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

A memory-mapped 16-bit timer that counts down from a value written by software. Software sets a reload value, chooses how the counter behaves when it passes zero (reload from the stored value, or wrap to all ones), picks a clock divider, and then enables counting. When the count passes below zero, the timer raises a level interrupt. The interrupt stays high until software writes the clear register.

Access is through a simple synchronous register port: an address, a write enable and write data sampled on the rising clock edge, and read data that follows the address combinationally. Reset is synchronous and active high. A system that needs two timers places two copies of the block.

Top module: `down_timer`

## Requirements
- R1: While reset is high and on the cycle after it is released, the load, value and control registers read 0, the interrupt is low and the counter does not move.
- R2: Reads return the stored load value at offset 0x0, the live count at 0x4 and the control register at 0x8. The control register has enable in bit 7, mode in bit 6 (1 = periodic, 0 = free-running) and the prescale code in bits 3:2. All other control bits read 0.
- R3: A write to offset 0x0 stores the load value and puts the same value into the counter at that clock edge. It also restarts the prescale period, and it takes priority over a decrement due in the same cycle.
- R4: A write to offset 0x4 has no effect on the count, the load value, the control bits or the interrupt.
- R5: Offset 0xC reads 0. Offsets 0x10 to 0x1F and any address with bits 1:0 not zero read 0 and ignore writes.
- R6: While enabled, the counter decrements once every 1, 16, 256 or 256 clock cycles for prescale codes 0, 1, 2 and 3.
- R7: While enable is 0, the count and the prescale phase hold their values.
- R8: In periodic mode, a decrement from 0 reloads the counter with the load value.
- R9: In free-running mode, a decrement from 0 sets the counter to 0xFFFF.
- R10: A decrement from 0 (an underflow) drives the interrupt high on the next edge. The interrupt stays high until a write to the clear register.
- R11: Any write to offset 0xC drives the interrupt low at that edge. An underflow in the same cycle wins, and the interrupt stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; everything samples on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| busAddr | input | 5 | Byte offset of the register access |
| busWe | input | 1 | Write enable for the current cycle |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for busAddr, combinational |
| irq | output | 1 | Level interrupt, high after an underflow until cleared |

## Verification
A wrong prescale phase shows up first as a count that moves one or more cycles early or late. It is visible on a read of offset 0x4 as soon as the next decrement is due, and the interrupt edge then arrives at the wrong moment too. A bad reload or wrap decision shows on the first read after an underflow. A corrupted control bit shows on a read of offset 0x8 in the next cycle. The bench runs a cycle-exact model of the requirements next to the design and compares read data and the interrupt on every cycle, so each of these faults is reported in the cycle where it first reaches a port.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Bit positions inside the control register
  localparam int EnBit     = 7;
  localparam int ModeBit   = 6;
  localparam int PsLsb     = 2;

  // Register index = byte offset / 4
  localparam int IdxLoad   = 0;
  localparam int IdxValue  = 1;
  localparam int IdxCtrl   = 2;
  localparam int IdxClear  = 3;

  typedef enum logic [1:0] {
    PS_DIV1    = 2'd0,
    PS_DIV16   = 2'd1,
    PS_DIV256  = 2'd2,
    PS_DIV256B = 2'd3
  } psSel_e;

  typedef struct packed {
    logic loadWr;
    logic ctrlWr;
    logic clrWr;
  } busStrobe_t;

  typedef struct packed {
    logic   enable;
    logic   periodic;
    psSel_e prescale;
  } tmrCfg_t;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int STEP_LOG = 4
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   run,
  input  logic   restart,
  input  psSel_e psSel,
  output logic   stepOut
);

  localparam int TICK_W = 2 * STEP_LOG;

  logic [TICK_W-1:0] tick;
  logic [TICK_W-1:0] periodM1;
  logic              periodEnd;

  always_comb begin
    unique case (psSel)
      PS_DIV1:  periodM1 = '0;
      PS_DIV16: periodM1 = TICK_W'((1 << STEP_LOG) - 1);
      default:  periodM1 = '1;
    endcase
  end

  // a shorter period chosen mid-count must not strand the phase above its end
  assign periodEnd = (tick >= periodM1);
  assign stepOut   = run && !restart && periodEnd;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick <= '0;
    end else if (restart) begin
      tick <= '0;
    end else if (run) begin
      if (periodEnd) tick <= '0;
      else           tick <= tick + 1'b1;
    end
  end

  // R3
  tick_restart_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (tick == '0));

  // R7
  tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(run) && !$past(restart)) |-> $stable(tick));

endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [CNT_W-1:0]  busWdata,
  input  logic [CNT_W-1:0]  loadVal,
  input  logic [CNT_W-1:0]  count,
  output busStrobe_t        strobe,
  output tmrCfg_t           cfg,
  output logic [CNT_W-1:0]  loadData,
  output logic [CNT_W-1:0]  busRdata
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] regIdx;
  logic             aligned;
  logic             ctrlWrLocal;

  assign regIdx   = busAddr[ADDR_W-1:2];
  assign aligned  = (busAddr[1:0] == 2'b00);
  assign loadData = busWdata;

  always_comb begin
    strobe = '0;
    if (busWe && aligned) begin
      unique case (regIdx)
        IDX_W'(IdxLoad):  strobe.loadWr = 1'b1;
        IDX_W'(IdxCtrl):  strobe.ctrlWr = 1'b1;
        IDX_W'(IdxClear): strobe.clrWr  = 1'b1;
        default:          strobe = '0;
      endcase
    end
  end

  assign ctrlWrLocal = strobe.ctrlWr;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '{enable: 1'b0, periodic: 1'b0, prescale: PS_DIV1};
    end else if (strobe.ctrlWr) begin
      cfg.enable   <= busWdata[EnBit];
      cfg.periodic <= busWdata[ModeBit];
      cfg.prescale <= psSel_e'(busWdata[PsLsb+1:PsLsb]);
    end
  end

  always_comb begin
    busRdata = '0;
    if (aligned) begin
      unique case (regIdx)
        IDX_W'(IdxLoad):  busRdata = loadVal;
        IDX_W'(IdxValue): busRdata = count;
        IDX_W'(IdxCtrl): begin
          busRdata[EnBit]             = cfg.enable;
          busRdata[ModeBit]           = cfg.periodic;
          busRdata[PsLsb+1:PsLsb]     = cfg.prescale;
        end
        default:          busRdata = '0;
      endcase
    end
  end

  // R4
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(ctrlWrLocal) |-> $stable(cfg));

endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int STEP_LOG = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  busStrobe_t       strobe,
  input  tmrCfg_t          cfg,
  input  logic [CNT_W-1:0] loadData,
  output logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] count,
  output logic             irq
);

  logic step;
  logic underflow;
  logic enable;
  logic periodic;
  logic loadWr;
  logic clrWr;

  assign enable   = cfg.enable;
  assign periodic = cfg.periodic;
  assign loadWr   = strobe.loadWr;
  assign clrWr    = strobe.clrWr;

  tmr_prescaler #(.STEP_LOG(STEP_LOG)) uPrescaler (
    .clk     (clk),
    .rst     (rst),
    .run     (enable),
    .restart (loadWr),
    .psSel   (cfg.prescale),
    .stepOut (step)
  );

  assign underflow = step && (count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      loadVal <= '0;
      count   <= '0;
    end else if (loadWr) begin
      loadVal <= loadData;
      count   <= loadData;
    end else if (step) begin
      if (count == '0) count <= periodic ? loadVal : '1;
      else             count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            irq <= 1'b0;
    else if (underflow) irq <= 1'b1;
    else if (clrWr)     irq <= 1'b0;
  end

  // R7
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(enable) && !$past(loadWr)) |-> $stable(count));

  // R8
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(underflow) && $past(periodic)) |-> (count == $past(loadVal)));

  // R9
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(underflow) && !$past(periodic)) |-> (count == '1));

  // R10
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(underflow));

  // R11
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(clrWr) && !$past(underflow)) |-> !irq);

endmodule

// File: rtl/down_timer.sv
module down_timer
  import tmr_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int CNT_W    = 16,
  parameter int STEP_LOG = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [CNT_W-1:0]  busWdata,
  output logic [CNT_W-1:0]  busRdata,
  output logic              irq
);

  busStrobe_t       strobe;
  tmrCfg_t          cfg;
  logic [CNT_W-1:0] loadData;
  logic [CNT_W-1:0] loadVal;
  logic [CNT_W-1:0] count;

  tmr_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uCtrl (
    .clk      (clk),
    .rst      (rst),
    .busAddr  (busAddr),
    .busWe    (busWe),
    .busWdata (busWdata),
    .loadVal  (loadVal),
    .count    (count),
    .strobe   (strobe),
    .cfg      (cfg),
    .loadData (loadData),
    .busRdata (busRdata)
  );

  tmr_datapath #(.CNT_W(CNT_W), .STEP_LOG(STEP_LOG)) uDatapath (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .cfg      (cfg),
    .loadData (loadData),
    .loadVal  (loadVal),
    .count    (count),
    .irq      (irq)
  );

endmodule

// File: tb/tb_down_timer.sv
`timescale 1ns/1ps
module tb_down_timer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  logic [15:0] mLoad, mCnt;
  int          mTick;
  bit          mEn, mPer, mIrq;
  logic [1:0]  mPs;
  logic [15:0] lastRd;

  always #2.5 clk = ~clk;

  down_timer dut (.clk(clk), .rst(rst), .busAddr(busAddr), .busWe(busWe),
                  .busWdata(busWdata), .busRdata(busRdata), .irq(irq));

  function automatic int perOf(logic [1:0] ps);
    case (ps)
      2'd0:    return 1;
      2'd1:    return 16;
      default: return 256;
    endcase
  endfunction

  function automatic logic [15:0] expRead(logic [4:0] a);
    if (a[1:0] != 2'b00) return 16'h0;
    case (a[4:2])
      3'd0:    return mLoad;
      3'd1:    return mCnt;
      3'd2:    return {8'h0, mEn, mPer, 2'b00, mPs, 2'b00};
      default: return 16'h0;
    endcase
  endfunction

  task automatic expect16(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    mLoad = '0; mCnt = '0; mTick = 0; mEn = 0; mPer = 0; mIrq = 0; mPs = '0;
  endtask

  // one bus cycle: drive, compare against model, advance model
  task automatic cyc(bit we, logic [4:0] a, logic [15:0] d, string tag);
    bit stp, und;
    @(negedge clk);
    busWe = we; busAddr = a; busWdata = d;
    #1;
    lastRd = busRdata;
    expect16(tag, busRdata, expRead(a));
    expect16("R10", {15'h0, irq}, {15'h0, mIrq});
    stp = 0; und = 0;
    if (we && a[1:0] == 2'b00 && a[4:2] == 3'd0) begin
      mLoad = d; mCnt = d; mTick = 0;
    end else if (mEn) begin
      if (mTick >= perOf(mPs) - 1) begin mTick = 0; stp = 1; end
      else mTick++;
    end
    if (stp) begin
      if (mCnt == 16'h0) begin und = 1; mCnt = mPer ? mLoad : 16'hFFFF; end
      else mCnt = mCnt - 1'b1;
    end
    if (und) mIrq = 1;
    else if (we && a[1:0] == 2'b00 && a[4:2] == 3'd3) mIrq = 0;
    if (we && a[1:0] == 2'b00 && a[4:2] == 3'd2) begin
      mEn = d[7]; mPer = d[6]; mPs = d[3:2];
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1; busWe = 0;
    repeat (3) @(negedge clk);
    modelReset();
    rst = 0;
  endtask

  // measure clock cycles between count changes
  task automatic measure(logic [1:0] ps, int expCycles, string tag);
    int n;
    cyc(1, 5'h08, 16'h0080 | {12'h0, ps, 2'b00}, "R2");
    cyc(1, 5'h00, 16'd2, "R3");
    n = 0;
    cyc(0, 5'h04, 0, tag);
    while (lastRd == 16'd2 && n < 400) begin
      n++;
      cyc(0, 5'h04, 0, tag);
    end
    expect16(tag, 16'(n), 16'(expCycles));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    modelReset();
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset state
    cyc(0, 5'h00, 0, "R1"); expect16("R1", lastRd, 16'h0);
    cyc(0, 5'h04, 0, "R1"); expect16("R1", lastRd, 16'h0);
    cyc(0, 5'h08, 0, "R1"); expect16("R1", lastRd, 16'h0);
    expect16("R1", {15'h0, irq}, 16'h0);

    // R3 load
    cyc(1, 5'h00, 16'd5, "R3");
    cyc(0, 5'h04, 0, "R3"); expect16("R3", lastRd, 16'd5);
    // R4 value register writes ignored
    cyc(1, 5'h04, 16'h1234, "R4");
    cyc(0, 5'h04, 0, "R4"); expect16("R4", lastRd, 16'd5);
    cyc(0, 5'h00, 0, "R4"); expect16("R4", lastRd, 16'd5);
    cyc(0, 5'h08, 0, "R4"); expect16("R4", lastRd, 16'h0);
    // R5 reserved and unaligned
    cyc(1, 5'h10, 16'hFFFF, "R5");
    cyc(1, 5'h09, 16'hFFFF, "R5");
    cyc(1, 5'h01, 16'hABCD, "R5");
    cyc(0, 5'h08, 0, "R5"); expect16("R5", lastRd, 16'h0);
    cyc(0, 5'h00, 0, "R5"); expect16("R5", lastRd, 16'd5);
    cyc(0, 5'h0C, 0, "R5"); expect16("R5", lastRd, 16'h0);
    cyc(0, 5'h10, 0, "R5"); expect16("R5", lastRd, 16'h0);
    cyc(0, 5'h05, 0, "R5"); expect16("R5", lastRd, 16'h0);
    // R7 disabled holds
    repeat (20) cyc(0, 5'h04, 0, "R7");
    expect16("R7", lastRd, 16'd5);
    // R2 control field layout
    cyc(1, 5'h08, 16'hFFFF, "R2");
    cyc(0, 5'h08, 0, "R2"); expect16("R2", lastRd, 16'h00CC);
    // R6 prescale periods
    measure(2'd0, 1, "R6");
    measure(2'd1, 16, "R6");
    measure(2'd2, 256, "R6");
    measure(2'd3, 256, "R6");
    // R9 free-running wrap
    cyc(1, 5'h08, 16'h0080, "R9");
    cyc(1, 5'h00, 16'd1, "R9");
    cyc(0, 5'h04, 0, "R9");
    cyc(0, 5'h04, 0, "R9");
    cyc(0, 5'h04, 0, "R9"); expect16("R9", lastRd, 16'hFFFF);
    expect16("R10", {15'h0, irq}, 16'h1);
    // R10 stays high with no clear
    repeat (10) cyc(0, 5'h04, 0, "R10");
    expect16("R10", {15'h0, irq}, 16'h1);
    // R11 clear
    cyc(1, 5'h0C, 16'h0, "R11");
    cyc(0, 5'h04, 0, "R11"); expect16("R11", {15'h0, irq}, 16'h0);
    // R8 periodic reload
    cyc(1, 5'h08, 16'h00C0, "R8");
    cyc(1, 5'h00, 16'd2, "R8");
    cyc(0, 5'h04, 0, "R8");
    cyc(0, 5'h04, 0, "R8");
    cyc(0, 5'h04, 0, "R8");
    cyc(0, 5'h04, 0, "R8"); expect16("R8", lastRd, 16'd2);
    // R11 underflow wins over clear in same cycle
    cyc(1, 5'h0C, 16'h0, "R11");
    for (int k = 0; k < 10 && !(mTick >= perOf(mPs) - 1 && mCnt == 0); k++)
      cyc(0, 5'h04, 0, "R11");
    cyc(1, 5'h0C, 16'h0, "R11");
    cyc(0, 5'h04, 0, "R11"); expect16("R11", {15'h0, irq}, 16'h1);
    // R3 load beats a due decrement
    cyc(1, 5'h00, 16'd7, "R3");
    cyc(0, 5'h04, 0, "R3"); expect16("R3", lastRd, 16'd7);

    // constrained random phase
    for (int i = 0; i < 6000; i++) begin
      int r;
      logic [4:0] a;
      r = $urandom_range(0, 99);
      a = 5'($urandom_range(0, 7) * 4);
      if (r < 8)       cyc(1, 5'h00, 16'($urandom_range(0, 40)), "R3");
      else if (r < 12) cyc(1, 5'h08, 16'($urandom) & 16'hFFF3 | 16'h0080, "R2");
      else if (r < 13) cyc(1, 5'h08, 16'($urandom), "R2");
      else if (r < 17) cyc(1, 5'h0C, 16'($urandom), "R11");
      else if (r < 19) cyc(1, 5'h04, 16'($urandom), "R4");
      else if (r < 21) cyc(1, 5'($urandom_range(16, 31)), 16'($urandom), "R5");
      else             cyc(0, a, 0, "R2");
    end

    // R1 reset mid-run
    cyc(1, 5'h08, 16'h00C0, "R1");
    doReset();
    cyc(0, 5'h08, 0, "R1"); expect16("R1", lastRd, 16'h0);
    cyc(0, 5'h00, 0, "R1"); expect16("R1", lastRd, 16'h0);
    cyc(0, 5'h04, 0, "R1"); expect16("R1", lastRd, 16'h0);
    expect16("R1", {15'h0, irq}, 16'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule